// File: doc/BRIEF.md
# Occlusion Query Result Reducer

When an occlusion query completes, the depth backends leave behind a small block of 64-bit snapshot words. There is one start/end pair for each backend. This block reads the words back through a simple request/valid read port and reduces them to a single visible-fragment total. For each backend it pairs the start snapshot with the end snapshot and checks the valid flag in the top bit of both words. Only when both flags are set does it add the 63-bit difference to a 64-bit total.

A single start strobe launches a reduction. The block then fetches the words one at a time and tolerates any number of stall cycles on the read port. When it finishes, it raises a done flag. Next to the sum it reports how many backends delivered valid data, so a caller can tell "nothing was visible" apart from "nothing was reported". The outputs hold their values until the next start strobe is accepted.

Top module: `oq_reduce`

## Requirements
- R1: After reset, `sum_o` is 0, `valid_cnt_o` is 0, `done_o` is 0 and `rd_req_o` is 0.
- R2: An accepted start causes exactly eight reads, one per cycle in which `rd_req_o` and `rd_valid_i` are both high. The reads use word indices 0 to 7 in ascending order on `rd_addr_o`. While `rd_req_o` is high and `rd_valid_i` is low, `rd_addr_o` holds its value and the request stays up.
- R3: Each backend uses two words: the word at index 2k is its start snapshot and the word at index 2k+1 is its end snapshot. A qualifying backend contributes end[62:0] minus start[62:0], zero-extended to 64 bits.
- R4: A backend whose start word or end word has bit 63 clear contributes nothing to the sum and is not counted.
- R5: `sum_o` is the 64-bit sum, modulo 2^64, of all qualifying contributions. Each accepted start clears the sum to zero before accumulation begins.
- R6: The difference is taken modulo 2^63, so an end count that has wrapped below its start count still yields the true delta.
- R7: `valid_cnt_o` equals the number of qualifying backends (0 to 4). It never exceeds 4 and grows by at most one per cycle.
- R8: `done_o` rises after the eighth word has been consumed. `done_o`, `sum_o` and `valid_cnt_o` then stay unchanged and `rd_req_o` stays low until the next start is accepted. An accepted start clears `done_o`.
- R9: A start strobe that arrives while a reduction is in progress is ignored. The running reduction still performs exactly eight reads and delivers its normal result.
- R10: The result does not depend on how many stall cycles the read port inserts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start-of-reduction strobe |
| rd_req_o | output | 1 | Read request for the word at `rd_addr_o` |
| rd_addr_o | output | 3 | Word index being requested |
| rd_valid_i | input | 1 | Read data valid; the word is consumed when `rd_req_o` is also high |
| rd_data_i | input | 64 | Read data word |
| sum_o | output | 64 | Visible-fragment total |
| valid_cnt_o | output | 3 | Number of backends with both flags set |
| done_o | output | 1 | Reduction complete; results are stable |

## Verification
A wrong word index or a lost handshake shows up at the read port within a single accepted read, because the index sequence is checked against its expected position. A fault in the flag qualification or the subtraction is only visible once `done_o` rises, a few cycles after the last word. The runs therefore mix pairs with both flags set, pairs with one flag set, pairs with neither flag set, and wrapped counters, so that each such fault changes either the sum or the valid count. An accumulator that was not cleared, or a start that was not ignored, shows up as a wrong total in the following run or in the current run.

// File: rtl/oq_reduce_pkg.sv
package oq_reduce_pkg;
   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_RUN   = 2'd1,
      FS_DRAIN = 2'd2
   } fetch_state_e;
endpackage

// File: rtl/oq_reduce_fetch.sv
module oq_reduce_fetch
   import oq_reduce_pkg::*;
#(
   parameter int WORD_W = 64,
   parameter int NUM_BE = 4,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              done_i,
   output logic              rd_req_o,
   output logic [IDX_W-1:0]  rd_addr_o,
   input  logic              rd_valid_i,
   input  logic [WORD_W-1:0] rd_data_i,
   output logic              clr_o,
   output logic              pair_vld_o,
   output logic              pair_last_o,
   output logic [WORD_W-1:0] start_word_o,
   output logic [WORD_W-1:0] end_word_o
);
   localparam int NUM_WORDS = 2 * NUM_BE;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

   fetch_state_e      state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [WORD_W-1:0] hold_q;
   logic              accept;

   assign rd_req_o     = (state_q == FS_RUN);
   assign rd_addr_o    = idx_q;
   assign accept       = rd_req_o && rd_valid_i;
   assign clr_o        = start_i && (state_q == FS_IDLE);
   assign pair_vld_o   = accept && idx_q[0];
   assign pair_last_o  = accept && (idx_q == LAST_IDX);
   assign start_word_o = hold_q;
   assign end_word_o   = rd_data_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         idx_q   <= '0;
         hold_q  <= '0;
      end else begin
         unique case (state_q)
            FS_IDLE: begin
               if (start_i) begin
                  state_q <= FS_RUN;
                  idx_q   <= '0;
               end
            end
            FS_RUN: begin
               if (accept) begin
                  if (!idx_q[0]) hold_q <= rd_data_i;
                  if (idx_q == LAST_IDX) state_q <= FS_DRAIN;
                  else                   idx_q   <= idx_q + IDX_W'(1);
               end
            end
            FS_DRAIN: begin
               if (done_i) state_q <= FS_IDLE;
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/oq_reduce_pair.sv
module oq_reduce_pair #(
   parameter int WORD_W    = 64,
   parameter bit PAIR_PIPE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              vld_i,
   input  logic              last_i,
   input  logic [WORD_W-1:0] start_w_i,
   input  logic [WORD_W-1:0] end_w_i,
   output logic              ev_vld_o,
   output logic              ev_use_o,
   output logic              ev_last_o,
   output logic [WORD_W-1:0] ev_delta_o
);
   localparam int FLAG = WORD_W - 1;

   logic              use_c;
   logic [WORD_W-1:0] delta_c;

   // Qualify on both flags; count field difference wraps naturally.
   assign use_c   = start_w_i[FLAG] && end_w_i[FLAG];
   assign delta_c = {1'b0, end_w_i[FLAG-1:0] - start_w_i[FLAG-1:0]};

   generate
      if (PAIR_PIPE) begin : g_pipe
         logic              vld_q, use_q, last_q;
         logic [WORD_W-1:0] delta_q;
         always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
               vld_q   <= 1'b0;
               use_q   <= 1'b0;
               last_q  <= 1'b0;
               delta_q <= '0;
            end else begin
               vld_q   <= vld_i;
               use_q   <= vld_i && use_c;
               last_q  <= vld_i && last_i;
               delta_q <= delta_c;
            end
         end
         assign ev_vld_o   = vld_q;
         assign ev_use_o   = use_q;
         assign ev_last_o  = last_q;
         assign ev_delta_o = delta_q;
      end else begin : g_comb
         assign ev_vld_o   = vld_i;
         assign ev_use_o   = vld_i && use_c;
         assign ev_last_o  = vld_i && last_i;
         assign ev_delta_o = delta_c;
      end
   endgenerate
endmodule

// File: rtl/oq_reduce_accum.sv
module oq_reduce_accum #(
   parameter int WORD_W = 64,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              ev_vld_i,
   input  logic              ev_use_i,
   input  logic              ev_last_i,
   input  logic [WORD_W-1:0] ev_delta_i,
   output logic [WORD_W-1:0] sum_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              done_o
);
   logic [WORD_W-1:0] sum_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              done_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         sum_q  <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (ev_vld_i) begin
         if (ev_use_i) begin
            sum_q <= sum_q + ev_delta_i;
            cnt_q <= cnt_q + CNT_W'(1);
         end
         if (ev_last_i) done_q <= 1'b1;
      end
   end

   assign sum_o  = sum_q;
   assign cnt_o  = cnt_q;
   assign done_o = done_q;
endmodule

// File: rtl/oq_reduce.sv
module oq_reduce #(
   parameter int WORD_W    = 64,
   parameter int NUM_BE    = 4,
   parameter bit PAIR_PIPE = 1'b1,
   localparam int NUM_WORDS = 2 * NUM_BE,
   localparam int IDX_W     = (NUM_WORDS > 2) ? $clog2(NUM_WORDS) : 1,
   localparam int CNT_W     = $clog2(NUM_BE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              rd_req_o,
   output logic [IDX_W-1:0]  rd_addr_o,
   input  logic              rd_valid_i,
   input  logic [WORD_W-1:0] rd_data_i,
   output logic [WORD_W-1:0] sum_o,
   output logic [CNT_W-1:0]  valid_cnt_o,
   output logic              done_o
);
   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("oq_reduce: WORD_W must be at least 2");
      end
      if (NUM_BE < 1) begin : g_bad_count
         $error("oq_reduce: NUM_BE must be at least 1");
      end
   endgenerate

   logic              clr;
   logic              pair_vld, pair_last;
   logic [WORD_W-1:0] start_word, end_word;
   logic              ev_vld, ev_use, ev_last;
   logic [WORD_W-1:0] ev_delta;

   oq_reduce_fetch #(
      .WORD_W (WORD_W),
      .NUM_BE (NUM_BE),
      .IDX_W  (IDX_W)
   ) fetch_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .done_i       (done_o),
      .rd_req_o     (rd_req_o),
      .rd_addr_o    (rd_addr_o),
      .rd_valid_i   (rd_valid_i),
      .rd_data_i    (rd_data_i),
      .clr_o        (clr),
      .pair_vld_o   (pair_vld),
      .pair_last_o  (pair_last),
      .start_word_o (start_word),
      .end_word_o   (end_word)
   );

   oq_reduce_pair #(
      .WORD_W    (WORD_W),
      .PAIR_PIPE (PAIR_PIPE)
   ) pair_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr),
      .vld_i      (pair_vld),
      .last_i     (pair_last),
      .start_w_i  (start_word),
      .end_w_i    (end_word),
      .ev_vld_o   (ev_vld),
      .ev_use_o   (ev_use),
      .ev_last_o  (ev_last),
      .ev_delta_o (ev_delta)
   );

   oq_reduce_accum #(
      .WORD_W (WORD_W),
      .CNT_W  (CNT_W)
   ) accum_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr),
      .ev_vld_i   (ev_vld),
      .ev_use_i   (ev_use),
      .ev_last_i  (ev_last),
      .ev_delta_i (ev_delta),
      .sum_o      (sum_o),
      .cnt_o      (valid_cnt_o),
      .done_o     (done_o)
   );
endmodule

// File: rtl/oq_reduce_chk.sv
module oq_reduce_chk #(
   parameter int WORD_W = 64,
   parameter int NUM_BE = 4,
   parameter int IDX_W  = 3,
   parameter int CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              rd_req_o,
   input logic [IDX_W-1:0]  rd_addr_o,
   input logic              rd_valid_i,
   input logic [WORD_W-1:0] sum_o,
   input logic [CNT_W-1:0]  valid_cnt_o,
   input logic              done_o
);
   AST_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      valid_cnt_o <= CNT_W'(NUM_BE)); // R7

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> (valid_cnt_o == $past(valid_cnt_o)) ||
                   (valid_cnt_o == $past(valid_cnt_o) + CNT_W'(1))); // R7

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_valid_i) |=> rd_req_o && $stable(rd_addr_o)); // R2

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> done_o && $stable(sum_o) && $stable(valid_cnt_o)); // R8

   AST_NO_REQ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !rd_req_o); // R8

   AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && start_i && !rd_valid_i) |=> rd_req_o && $stable(rd_addr_o)); // R9
endmodule

bind oq_reduce oq_reduce_chk #(
   .WORD_W (WORD_W),
   .NUM_BE (NUM_BE),
   .IDX_W  (IDX_W),
   .CNT_W  (CNT_W)
) chk_i (.*);

// File: tb/oq_reduce_tb_top.sv
`timescale 1ns/1ps
module oq_reduce_tb_top;
   typedef struct {
      logic [63:0] sum;
      logic [2:0]  cnt;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        rd_req_o;
   logic [2:0]  rd_addr_o;
   logic        rd_valid_i = 1'b0;
   logic [63:0] rd_data_i = '0;
   logic [63:0] sum_o;
   logic [2:0]  valid_cnt_o;
   logic        done_o;

   int tests = 0;
   int fails = 0;
   logic [63:0] mem [8];
   int  stall_mode = 0;
   int  cyc = 0;
   int  reads = 0;
   int  exp_idx = 0;
   logic done_d = 1'b0;
   exp_t sb [$];

   always #5 clk = ~clk;

   oq_reduce dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .rd_req_o    (rd_req_o),
      .rd_addr_o   (rd_addr_o),
      .rd_valid_i  (rd_valid_i),
      .rd_data_i   (rd_data_i),
      .sum_o       (sum_o),
      .valid_cnt_o (valid_cnt_o),
      .done_o      (done_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Reference model built from the requirements (R3, R4, R5, R6)
   function automatic exp_t model(input string tag);
      exp_t e;
      e.sum = '0; e.cnt = '0; e.tag = tag;
      for (int p = 0; p < 4; p++) begin
         logic [63:0] s, t;
         s = mem[2*p]; t = mem[2*p+1];
         if (s[63] && t[63]) begin
            e.sum = e.sum + {1'b0, t[62:0] - s[62:0]};
            e.cnt = e.cnt + 3'd1;
         end
      end
      return e;
   endfunction

   // Read responder with optional stalls; checks word order (R2)
   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rd_req_o && (stall_mode == 0 || (cyc % 3) == 0)) begin
         rd_valid_i = 1'b1;
         rd_data_i  = mem[rd_addr_o];
         chk(rd_addr_o == 3'(exp_idx), "R2", "read index",
             64'(rd_addr_o), 64'(exp_idx));
         exp_idx++;
         reads++;
      end else begin
         rd_valid_i = 1'b0;
         rd_data_i  = 64'hDEAD_BEEF_0BAD_F00D;
      end
   end

   // Monitor: pop expected result on each rising done
   always @(negedge clk) begin
      if (rst_n && done_o && !done_d) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R8", "unexpected done", 64'd1, 64'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(sum_o == e.sum, e.tag, "sum (R5)", sum_o, e.sum);
            chk(valid_cnt_o == e.cnt, e.tag, "valid count (R7)",
                64'(valid_cnt_o), 64'(e.cnt));
         end
      end
      done_d = done_o;
   end

   task automatic run_q(input int stall, input bit poke, input string tag);
      logic [63:0] held;
      int guard;
      stall_mode = stall;
      sb.push_back(model(tag));
      reads = 0; exp_idx = 0;
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      if (poke) begin
         repeat (4) @(negedge clk);
         start_i = 1'b1;   // R9: strobe during a running reduction
         @(negedge clk) start_i = 1'b0;
      end
      guard = 0;
      while (!done_o && guard < 1000) begin
         @(negedge clk);
         guard++;
      end
      chk(done_o == 1'b1, tag, "done reached (R8)", 64'(done_o), 64'd1);
      @(negedge clk);
      chk(reads == 8, tag, "read count (R2)", 64'(reads), 64'd8);
      held = sum_o;
      repeat (4) @(negedge clk);
      chk(done_o == 1'b1, "R8", "done held", 64'(done_o), 64'd1);
      chk(sum_o == held, "R8", "sum held", sum_o, held);
      chk(rd_req_o == 1'b0, "R8", "no request after done", 64'(rd_req_o), 64'd0);
   endtask

   task automatic set_pair(input int p, input bit fs, input logic [62:0] s,
                           input bit fe, input logic [62:0] e);
      mem[2*p]   = {fs, s};
      mem[2*p+1] = {fe, e};
   endtask

   initial begin
      #2_000_000;
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(sum_o == 64'd0, "R1", "sum after reset", sum_o, 64'd0);
      chk(valid_cnt_o == 3'd0, "R1", "count after reset", 64'(valid_cnt_o), 64'd0);
      chk(done_o == 1'b0, "R1", "done after reset", 64'(done_o), 64'd0);
      chk(rd_req_o == 1'b0, "R1", "request after reset", 64'(rd_req_o), 64'd0);

      // R3/R5: all four backends valid, sum 1110
      set_pair(0, 1, 63'd100, 1, 63'd150);
      set_pair(1, 1, 63'd200, 1, 63'd260);
      set_pair(2, 1, 63'd300, 1, 63'd300);
      set_pair(3, 1, 63'd400, 1, 63'd1400);
      run_q(0, 0, "R3");

      // R4: mixed flags, only pairs 0 and 2 qualify
      set_pair(0, 1, 63'd5,  1, 63'd25);
      set_pair(1, 0, 63'd10, 1, 63'd900);
      set_pair(2, 1, 63'd7,  1, 63'd8);
      set_pair(3, 1, 63'd50, 0, 63'd5000);
      run_q(0, 0, "R4");

      // R4/R7: no valid backend, sum 0 count 0 (also proves clear, R5)
      set_pair(0, 0, 63'd1, 0, 63'd99);
      set_pair(1, 0, 63'd1, 1, 63'd99);
      set_pair(2, 1, 63'd1, 0, 63'd99);
      set_pair(3, 0, 63'd0, 0, 63'd0);
      run_q(0, 0, "R7");

      // R6: wrapped end counters
      set_pair(0, 1, 63'h7FFF_FFFF_FFFF_FFFB, 1, 63'd10);
      set_pair(1, 1, 63'd3, 1, 63'd4);
      set_pair(2, 1, 63'h7FFF_FFFF_FFFF_FFFF, 1, 63'd0);
      set_pair(3, 0, 63'd0, 0, 63'd0);
      run_q(0, 0, "R6");

      // R5: 64-bit sum wraps with four maximal deltas
      for (int p = 0; p < 4; p++) set_pair(p, 1, 63'd0, 1, 63'h7FFF_FFFF_FFFF_FFFF);
      run_q(0, 0, "R5");

      // R10: stalled read port, same data as first case
      set_pair(0, 1, 63'd100, 1, 63'd150);
      set_pair(1, 1, 63'd200, 1, 63'd260);
      set_pair(2, 1, 63'd300, 1, 63'd300);
      set_pair(3, 1, 63'd400, 1, 63'd1400);
      run_q(1, 0, "R10");

      // R9: start strobe during a stalled run is ignored
      set_pair(0, 1, 63'd11, 1, 63'd111);
      set_pair(1, 1, 63'd0,  1, 63'd2);
      set_pair(2, 0, 63'd4,  1, 63'd40);
      set_pair(3, 1, 63'd9,  1, 63'd19);
      run_q(1, 1, "R9");

      chk(sb.size() == 0, "R8", "results outstanding", 64'(sb.size()), 64'd0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule